// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block turns a 20-bit processor address into chip selects for a 1 MB memory space. The space holds one 512 KB read-only program store and five 128 KB RAMs. The address is split into eight 128 KB slices, and the slice number is `addr[19:17]`.

Slices 0 to 2 (00000h–5FFFFh) always belong to the program store. Slice 3 (60000h–7FFFFh) is an overlay window. A one-bit bank select decides whether that window answers from the program store or from RAM 0, which holds waveforms. Slices 4 to 7 (80000h–FFFFFh) map to RAM 1 to RAM 4 in order. RAM 1 to RAM 3 hold waveforms, and RAM 4 (E0000h–FFFFFh) is the system working memory.

The bank select bit sits in a one-bit register. Software writes it and reads it back through a small I/O port at port number 40h. The memory side is purely combinational from the address, the strobes and that register. All strobes and selects are plain level signals. No data stream passes through the block, so it has no valid/ready interface.

Top module: `mem_bank_decoder`

## Requirements
- R1: After reset the bank select bit is 0. An I/O read of port 40h returns 00h, and reads in 60000h–7FFFFh select the program store.
- R2: A read cycle in 00000h–5FFFFh drives `rom_cs_n` and `rom_oe_n` low and every RAM select high.
- R3: In 60000h–7FFFFh, a read with the bank bit at 0 selects the program store. With the bit at 1, reads and writes select RAM 0 (`ram_cs_n[0]` low) and never the program store.
- R4: An access in 80000h–FFFFFh selects RAM k, with k = `addr[19:17]` − 3, so k runs from 1 to 4. RAM 4 is selected for E0000h–FFFFFh.
- R5: A write cycle that targets the program store asserts no select and no enable. This covers 00000h–5FFFFh always, and 60000h–7FFFFh while the bank bit is 0.
- R6: At most one chip select is low at any time. None is low unless `mem_req` is 1 and exactly one of `rd` and `wr` is 1.
- R7: `ram_oe_n` is low only in a read cycle that selects a RAM. `ram_we_n` is low only in a write cycle that selects a RAM. `rom_oe_n` is low only when the program store is selected.
- R8: An I/O write to port 40h loads `io_wdata[0]` into the bank bit at the next rising clock edge. A memory access in the same cycle still decodes with the old value. Writes to any other port leave the bit unchanged.
- R9: An I/O read of port 40h returns {7'b0, bank bit} on `io_rdata`. Otherwise `io_rdata` is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bank select register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Processor memory address |
| mem_req | input | 1 | Memory request, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| io_addr | input | 8 | I/O port number |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data; bit 0 is the bank select |
| io_rdata | output | 8 | I/O read data |
| rom_cs_n | output | 1 | Program store chip select, active low |
| rom_oe_n | output | 1 | Program store output enable, active low |
| ram_cs_n | output | 5 | RAM chip selects, active low; bit 0 is the overlay RAM, bit 4 the system RAM |
| ram_oe_n | output | 1 | Shared RAM output enable, active low |
| ram_we_n | output | 1 | Shared RAM write enable, active low |

## Verification
Two functions can fall in the same cycle: a register write that flips the bank bit, and a memory access inside the overlay window. The bench provokes this by driving an I/O write to port 40h in the same cycle as an overlay read, and again in the same cycle as an overlay write. In that cycle it expects the decode to follow the old bit. In the following cycle, with the same access held, it expects the new routing. A full sweep covers every slice, four offsets per slice, both bank-bit values and all eight strobe combinations, and each result is compared against an arithmetic model of the map.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  // A memory cycle needs the request and exactly one strobe.
  function automatic cyc_e classify(input logic req, input logic rd, input logic wr);
    if (req && rd && !wr)      return CYC_READ;
    else if (req && wr && !rd) return CYC_WRITE;
    else                       return CYC_IDLE;
  endfunction
endpackage

// File: rtl/mbd_region_decode.sv
module mbd_region_decode #(
  parameter int IDX_W      = 3,
  parameter int ROM_SLICES = 4,
  parameter int HIGH       = 4
) (
  input  logic [IDX_W-1:0] slice,
  output logic             in_fixed_rom,
  output logic             in_overlay,
  output logic [HIGH-1:0]  in_high
);
  // The last slice of the program-store window is the overlay window.
  assign in_fixed_rom = (int'(slice) < ROM_SLICES - 1);
  assign in_overlay   = (int'(slice) == ROM_SLICES - 1);

  for (genvar g = 0; g < HIGH; g++) begin : g_high
    assign in_high[g] = (int'(slice) == ROM_SLICES + g);
  end
endmodule

// File: rtl/mbd_overlay_reg.sv
module mbd_overlay_reg #(
  parameter int          IO_AW  = 8,
  parameter int          IO_DW  = 8,
  parameter logic [7:0]  PORT   = 8'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [IO_DW-1:0] io_wdata,
  output logic [IO_DW-1:0] io_rdata,
  output logic             bank_sel
);
  logic hit_wr, hit_rd;
  assign hit_wr = io_wr && (io_addr == IO_AW'(PORT));
  assign hit_rd = io_rd && (io_addr == IO_AW'(PORT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bank_sel <= 1'b0;
    else if (hit_wr) bank_sel <= io_wdata[0];
  end

  assign io_rdata = hit_rd ? {{(IO_DW-1){1'b0}}, bank_sel} : '0;

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^io_wdata[IO_DW-1:1];

  p_bank_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IO_AW'(PORT)) |=> (bank_sel == $past(io_wdata[0])));
  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == IO_AW'(PORT)) |=> $stable(bank_sel));
  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == '0));
endmodule

// File: rtl/mbd_select_gen.sv
module mbd_select_gen
  import mbd_pkg::*;
#(
  parameter int HIGH = 4,
  parameter int NRAM = HIGH + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_req,
  input  logic            rd,
  input  logic            wr,
  input  logic            bank_sel,
  input  logic            in_fixed_rom,
  input  logic            in_overlay,
  input  logic [HIGH-1:0] in_high,
  output logic            rom_cs,
  output logic            rom_oe,
  output logic [NRAM-1:0] ram_cs,
  output logic            ram_oe,
  output logic            ram_we
);
  cyc_e cyc;
  logic is_rd, is_wr, active, ram_any;

  assign cyc    = classify(mem_req, rd, wr);
  assign is_rd  = (cyc == CYC_READ);
  assign is_wr  = (cyc == CYC_WRITE);
  assign active = is_rd || is_wr;

  // The program store only answers reads; writes to it go nowhere.
  assign rom_cs = is_rd && (in_fixed_rom || (in_overlay && !bank_sel));
  assign rom_oe = rom_cs;

  assign ram_cs[0] = active && in_overlay && bank_sel;
  for (genvar g = 0; g < HIGH; g++) begin : g_ram
    assign ram_cs[g+1] = active && in_high[g];
  end

  assign ram_any = |ram_cs;
  assign ram_oe  = is_rd && ram_any;
  assign ram_we  = is_wr && ram_any;

  p_one_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs}));
  p_idle_no_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req || (rd == wr)) |-> !(rom_cs || ram_any));
  p_rom_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !rom_cs);
  p_oe_we_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_oe && ram_we));
  p_rom_oe_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_oe |-> (rd && !wr && mem_req));
endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder #(
  parameter int         ADDR_W     = 20,
  parameter int         SLICE_W    = 17,
  parameter int         ROM_SLICES = 4,
  parameter int         IO_AW      = 8,
  parameter int         IO_DW      = 8,
  parameter logic [7:0] BANK_PORT  = 8'h40,
  parameter int         IDX_W      = ADDR_W - SLICE_W,
  parameter int         HIGH       = (1 << IDX_W) - ROM_SLICES,
  parameter int         NRAM       = HIGH + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_req,
  input  logic              rd,
  input  logic              wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [IO_DW-1:0]  io_wdata,
  output logic [IO_DW-1:0]  io_rdata,
  output logic              rom_cs_n,
  output logic              rom_oe_n,
  output logic [NRAM-1:0]   ram_cs_n,
  output logic              ram_oe_n,
  output logic              ram_we_n
);
  logic            bank_sel, in_fixed_rom, in_overlay;
  logic [HIGH-1:0] in_high;
  logic            rom_cs, rom_oe, ram_oe, ram_we;
  logic [NRAM-1:0] ram_cs;

  logic unused_addr_bits;
  assign unused_addr_bits = ^addr[SLICE_W-1:0];

  mbd_region_decode #(.IDX_W(IDX_W), .ROM_SLICES(ROM_SLICES), .HIGH(HIGH)) u_region (
    .slice(addr[ADDR_W-1:SLICE_W]), .in_fixed_rom(in_fixed_rom),
    .in_overlay(in_overlay), .in_high(in_high)
  );

  mbd_overlay_reg #(.IO_AW(IO_AW), .IO_DW(IO_DW), .PORT(BANK_PORT)) u_bank (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .bank_sel(bank_sel)
  );

  mbd_select_gen #(.HIGH(HIGH), .NRAM(NRAM)) u_sel (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .rd(rd), .wr(wr),
    .bank_sel(bank_sel), .in_fixed_rom(in_fixed_rom), .in_overlay(in_overlay),
    .in_high(in_high), .rom_cs(rom_cs), .rom_oe(rom_oe), .ram_cs(ram_cs),
    .ram_oe(ram_oe), .ram_we(ram_we)
  );

  assign rom_cs_n = ~rom_cs;
  assign rom_oe_n = ~rom_oe;
  assign ram_cs_n = ~ram_cs;
  assign ram_oe_n = ~ram_oe;
  assign ram_we_n = ~ram_we;

  p_overlay_ram_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n[0] |-> (addr[ADDR_W-1:SLICE_W] == IDX_W'(ROM_SLICES - 1)));
  p_system_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n[NRAM-1] |-> (&addr[ADDR_W-1:SLICE_W]));
endmodule

// File: tb/mem_bank_decoder_bench.sv
module mem_bank_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        mem_req = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0]  io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        rom_cs_n, rom_oe_n, ram_oe_n, ram_we_n;
  logic [4:0]  ram_cs_n;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mem_bank_decoder u_mem_bank_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mem_req(mem_req), .rd(rd), .wr(wr),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n),
    .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
  );

  // Expected {rom_cs_n, rom_oe_n, ram_cs_n[4:0], ram_oe_n, ram_we_n} from the memory map.
  function automatic logic [8:0] model(input logic [19:0] a, input logic bank,
                                       input logic q, input logic r, input logic w);
    int   s;
    int   k;
    logic rc, wc, rom;
    logic [4:0] rams;
    s   = int'(a[19:17]);
    rc  = q && r && !w;
    wc  = q && w && !r;
    rom = rc && (s < 3 || (s == 3 && !bank));
    k   = -1;
    if (s == 3 && bank) k = 0;
    else if (s >= 4)    k = s - 3;
    rams = '0;
    if ((rc || wc) && k >= 0) rams[k] = 1'b1;
    return {~rom, ~rom, ~rams, ~(rc && |rams), ~(wc && |rams)};
  endfunction

  task automatic check_vec(input string tag, input logic [8:0] exp);
    logic [8:0] act;
    act = {rom_cs_n, rom_oe_n, ram_cs_n, ram_oe_n, ram_we_n};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/R7 addr=%h req=%b rd=%b wr=%b actual=%b expected=%b",
               tag, addr, mem_req, rd, wr, act, exp);
    end
  endtask

  task automatic check_byte(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] port, input logic [7:0] d);
    @(negedge clk);
    io_addr = port; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read_check(input string tag, input logic [7:0] port, input logic [7:0] exp);
    @(negedge clk);
    io_addr = port; io_rd = 1'b1;
    #2 check_byte(tag, io_rdata, exp);
    io_rd = 1'b0;
    #1 check_byte({tag, " idle"}, io_rdata, 8'h00);
  endtask

  function automatic string tag_of(input logic [19:0] a, input logic bank,
                                   input logic q, input logic r, input logic w);
    int s;
    s = int'(a[19:17]);
    if (!(q && (r ^ w)))                          return "R6";
    if (w && (s < 3 || (s == 3 && !bank)))        return "R5";
    if (s < 3)                                    return "R2";
    if (s == 3)                                   return "R3";
    return "R4";
  endfunction

  initial begin
    int timeout = 0;
    forever begin
      @(posedge clk);
      timeout++;
      if (timeout > 100000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [19:0] offs [4];
    offs[0] = 20'h00000; offs[1] = 20'h00001; offs[2] = 20'h1FFFF; offs[3] = 20'h0A5C3;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of the bank bit, its readback and overlay routing
    io_read_check("R1 reset readback", 8'h40, 8'h00);
    @(negedge clk);
    addr = 20'h60000; mem_req = 1'b1; rd = 1'b1;
    #2 check_vec("R1", model(addr, 1'b0, 1'b1, 1'b1, 1'b0));
    mem_req = 1'b0; rd = 1'b0;

    // Sweep: both bank settings, every slice, four offsets, all strobe combinations
    for (int b = 0; b < 2; b++) begin
      io_write(8'h40, b[0] ? 8'hFF : 8'hFE);
      io_read_check("R9 readback", 8'h40, {7'b0, b[0]});
      for (int s = 0; s < 8; s++) begin
        for (int o = 0; o < 4; o++) begin
          for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            addr = (20'(s) << 17) | offs[o];
            mem_req = c[2]; rd = c[1]; wr = c[0];
            #2 check_vec(tag_of(addr, b[0], c[2], c[1], c[0]),
                         model(addr, b[0], c[2], c[1], c[0]));
          end
        end
      end
    end
    mem_req = 1'b0; rd = 1'b0; wr = 1'b0;

    // R8: writes to other ports are ignored (bank bit is 1 here)
    io_write(8'h41, 8'h00);
    io_write(8'hC0, 8'h00);
    io_read_check("R8 other port ignored", 8'h40, 8'h01);
    io_read_check("R9 other port reads zero", 8'h41, 8'h00);

    // R8: bank write in the same cycle as an overlay read decodes with the old bit
    @(negedge clk);
    addr = 20'h7FFFF; mem_req = 1'b1; rd = 1'b1;
    io_addr = 8'h40; io_wdata = 8'h00; io_wr = 1'b1;
    #2 check_vec("R8 same-cycle old", model(addr, 1'b1, 1'b1, 1'b1, 1'b0));
    @(negedge clk);
    io_wr = 1'b0;
    #2 check_vec("R8 next-cycle new", model(addr, 1'b0, 1'b1, 1'b1, 1'b0));

    // R8: same collision with an overlay write, switching back to RAM
    @(negedge clk);
    rd = 1'b0; wr = 1'b1;
    io_wdata = 8'h01; io_wr = 1'b1;
    #2 check_vec("R8 write old bit", model(addr, 1'b0, 1'b1, 1'b0, 1'b1));
    @(negedge clk);
    io_wr = 1'b0;
    #2 check_vec("R8 write new bit", model(addr, 1'b1, 1'b1, 1'b0, 1'b1));
    mem_req = 1'b0; wr = 1'b0;
    io_read_check("R9 final readback", 8'h40, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule